// File: doc/BRIEF.md
# Two-Stage Boot Watchdog Controller

This block supervises a board's start-up in two consecutive guarded phases. Once reset is released, a first guard timer begins counting. Boot firmware must retire it within its window by writing a dedicated 16-bit command word. Retiring the first guard arms the second guard at once. The second guard covers the operating-system load and is retired by a different command word. If either guard runs out, the block emits a one-cycle hard-reset request toward the board reset logic. It also records which guard fired.

A static strap enables or disables the whole feature. The strap is read once, at the first clock edge after reset release. A prescaler derives a one-second timebase from the system clock. A simulation override (`SIM_DIV`) shrinks the number of clock cycles per "second" so that test runs stay short. The timeout cause bits sit on the power-on reset only, so they remain readable after the reset that the block itself requested.

Top module: `bwd_boot_watchdog`

## Requirements
- R1: The strap is sampled at the first clock edge after the reset is released. If it is low, both guards stay inactive (status[1:0] = 0) and reset_req never rises until the next reset.
- R2: If the strap is high at that edge, guard 1 becomes active (status[0] = 1, status[1] = 0) from that same edge.
- R3: If guard 1 is never retired, reset_req is high after clock edge number 1 + GUARD1_SEC*DIV, counted from the reset release. DIV is SIM_DIV when SIM_DIV > 0, and otherwise CLK_HZ.
- R4: A write of 16'hEEA1 captured while guard 1 is active retires guard 1 and arms guard 2 on the same edge, so status[1:0] becomes 2'b10.
- R5: If guard 2 is never retired, reset_req is high after edge W + GUARD2_SEC*DIV, where W is the edge that captured the retiring write of guard 1.
- R6: A write of 16'hBBC2 captured while guard 2 is active retires guard 2. Both active bits then read 0 and no reset request follows until the next reset.
- R7: The following writes change nothing: a command word meant for the guard that is not active, any other data value, and any write while no guard is active.
- R8: reset_req is high for exactly one cycle per timeout. After a timeout, both active bits stay 0 until the next reset.
- R9: A guard 1 timeout sets status[2] and clears status[3]. A guard 2 timeout sets status[3] and clears status[2]. Both bits keep their value through rst_n and are cleared only by por_n.
- R10: Changing the strap after reset release has no effect until the next reset.
- R11: If a retiring write is captured on the same edge as the guard's expiry, the timeout takes priority and reset_req fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the cause bits |
| rst_n | input | 1 | Board reset, active low; restarts the guard sequence |
| strap_en | input | 1 | Static enable strap, 1 = watchdogs enabled |
| cmd_we | input | 1 | Write strobe for the command/status register |
| cmd_wdata | input | 16 | Data written to the command/status register |
| status | output | 4 | [0] guard 1 active, [1] guard 2 active, [2] last timeout from guard 1, [3] last timeout from guard 2 |
| reset_req | output | 1 | One-cycle hard-reset request pulse |

## Verification
The bench measures the exact edge at which each guard expires. A prescaler or terminal count that is off by one cycle therefore shows up as a wrong edge count. It writes the guard 1 command on the last edge before expiry and again on the expiry edge itself. A wrong priority between service and timeout then either misses the request or fires when it should not. Each guard's command is also sent to the other guard, together with random junk values. A loose decoder would then advance or disable a stage. Finally, the bench applies rst_n alone, then por_n, to show that the cause bits survive the first and clear on the second. It also toggles the strap after release to show it is latched only once.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
   typedef enum logic [2:0] {
      ST_BOOT,
      ST_GUARD1,
      ST_GUARD2,
      ST_QUIET,
      ST_TRIPPED
   } bwd_state_e;

   localparam int CMD_W = 16;
   localparam logic [CMD_W-1:0] CMD_RETIRE1 = 16'hEEA1;
   localparam logic [CMD_W-1:0] CMD_RETIRE2 = 16'hBBC2;
   localparam int STAT_W = 4;
   localparam int NUM_GUARDS = 2;
endpackage

// File: rtl/bwd_prescaler.sv
module bwd_prescaler #(
   parameter int DIV = 250_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("bwd_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_passthru
      wire unused_inputs = clk ^ rst_n ^ clr;
      assign tick = en;
   end else begin : g_count
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt_q <= '0;
         else if (!en || clr)       cnt_q <= '0;
         else if (cnt_q == LAST)    cnt_q <= '0;
         else                       cnt_q <= cnt_q + 1'b1;
      end

      assign tick = en && (cnt_q == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);  // R3
   end
endmodule

// File: rtl/bwd_stage_timer.sv
module bwd_stage_timer #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic expire
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("bwd_stage_timer: LIMIT must be at least 1");
   end

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TERM = CW'(LIMIT - 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run)          cnt_q <= '0;
      else if (tick)          cnt_q <= (cnt_q == TERM) ? '0 : cnt_q + 1'b1;
   end

   assign expire = run && tick && (cnt_q == TERM);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= TERM));  // R3
endmodule

// File: rtl/bwd_boot_watchdog.sv
module bwd_boot_watchdog #(
   parameter int CLK_HZ     = 250_000_000,
   parameter int SIM_DIV    = 0,
   parameter int GUARD1_SEC = 8,
   parameter int GUARD2_SEC = 108
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        rst_n,
   input  logic        strap_en,
   input  logic        cmd_we,
   input  logic [15:0] cmd_wdata,
   output logic [3:0]  status,
   output logic        reset_req
);
   import bwd_pkg::*;

   localparam int DIV = (SIM_DIV > 0) ? SIM_DIV : CLK_HZ;

   if (CLK_HZ < 1) begin : g_bad_clk
      $error("bwd_boot_watchdog: CLK_HZ must be positive");
   end
   if (SIM_DIV < 0) begin : g_bad_sim
      $error("bwd_boot_watchdog: SIM_DIV must not be negative");
   end
   if (GUARD1_SEC < 1 || GUARD2_SEC < 1) begin : g_bad_sec
      $error("bwd_boot_watchdog: guard periods must be at least 1 s");
   end

   logic sys_rst_n;
   assign sys_rst_n = rst_n & por_n;

   bwd_state_e state_q, state_d;
   logic       fire_d, fire_q;
   logic [1:0] cause_q;
   logic [NUM_GUARDS-1:0] run, expire;
   logic       tick, arm_clr;

   assign run[0]  = (state_q == ST_GUARD1);
   assign run[1]  = (state_q == ST_GUARD2);
   assign arm_clr = (state_d != state_q);

   bwd_prescaler #(.DIV(DIV)) u_presc (
      .clk  (clk),
      .rst_n(sys_rst_n),
      .en   (|run),
      .clr  (arm_clr),
      .tick (tick)
   );

   for (genvar g = 0; g < NUM_GUARDS; g++) begin : g_guard
      localparam int LIM = (g == 0) ? GUARD1_SEC : GUARD2_SEC;
      bwd_stage_timer #(.LIMIT(LIM)) u_tmr (
         .clk   (clk),
         .rst_n (sys_rst_n),
         .run   (run[g]),
         .tick  (tick),
         .expire(expire[g])
      );
   end

   always_comb begin
      state_d = state_q;
      fire_d  = 1'b0;
      unique case (state_q)
         ST_BOOT:   state_d = strap_en ? ST_GUARD1 : ST_QUIET;
         ST_GUARD1: begin
            if (expire[0]) begin
               state_d = ST_TRIPPED;
               fire_d  = 1'b1;
            end else if (cmd_we && cmd_wdata == CMD_RETIRE1) begin
               state_d = ST_GUARD2;
            end
         end
         ST_GUARD2: begin
            if (expire[1]) begin
               state_d = ST_TRIPPED;
               fire_d  = 1'b1;
            end else if (cmd_we && cmd_wdata == CMD_RETIRE2) begin
               state_d = ST_QUIET;
            end
         end
         ST_QUIET:   state_d = ST_QUIET;
         ST_TRIPPED: state_d = ST_TRIPPED;
         default:    state_d = ST_TRIPPED;
      endcase
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         state_q <= ST_BOOT;
         fire_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         fire_q  <= fire_d;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                 cause_q <= 2'b00;
      else if (rst_n && fire_d)   cause_q <= expire[0] ? 2'b01 : 2'b10;
   end

   assign reset_req = fire_q;
   assign status    = {cause_q, run[1], run[0]};

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!sys_rst_n)
      reset_req |=> !reset_req);  // R8
   AST_REQ_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!sys_rst_n)
      reset_req |-> (status[1:0] == 2'b00));  // R8
   AST_CAUSE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0(cause_q));  // R9
   AST_GUARD2_FROM_GUARD1: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $rose(status[1]) |-> $past(status[0]));  // R4
   AST_QUIET_STAYS: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (state_q == ST_QUIET) |=> (state_q == ST_QUIET && !reset_req));  // R6
   AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (state_q == ST_QUIET) |-> !fire_d);  // R1
endmodule

// File: tb/tb_bwd_boot_watchdog.sv
`timescale 1ns/1ps
module tb_bwd_boot_watchdog;
   localparam int DIV = 4;
   localparam int G1  = 8;
   localparam int G2  = 108;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, rst_n = 1'b0, strap_en = 1'b0, cmd_we = 1'b0;
   logic [15:0] cmd_wdata = '0;
   logic [3:0]  status;
   logic        reset_req;

   int n_chk = 0, n_bad = 0;
   logic [1:0] exp_cause = 2'b00;

   always #2 clk = ~clk;

   bwd_boot_watchdog #(.CLK_HZ(250_000_000), .SIM_DIV(DIV),
                       .GUARD1_SEC(G1), .GUARD2_SEC(G2)) dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap_en(strap_en),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .status(status), .reset_req(reset_req));

   function automatic int edges_to_fire(int sec);
      return 1 + sec * DIV;
   endfunction

   function automatic logic [3:0] exp_status(logic g1, logic g2);
      return {exp_cause, g2, g1};
   endfunction

   task automatic chk(int act, int exp, string tag);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(logic strap, logic por);
      @(negedge clk);
      rst_n = 1'b0;
      if (por) begin por_n = 1'b0; exp_cause = 2'b00; end
      repeat (3) @(negedge clk);
      strap_en = strap;
      por_n = 1'b1;
      rst_n = 1'b1;
   endtask

   task automatic wr(logic [15:0] v);
      cmd_we = 1'b1; cmd_wdata = v;
      @(negedge clk);
      cmd_we = 1'b0; cmd_wdata = '0;
   endtask

   task automatic measure_fire(int lim, output int cnt);
      cnt = 0;
      while (cnt < lim) begin
         @(negedge clk);
         cnt++;
         if (reset_req) break;
      end
   endtask

   task automatic watch_quiet(int n, output int seen);
      seen = 0;
      repeat (n) begin
         @(negedge clk);
         if (reset_req) seen = 1;
      end
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int c, s;
      logic [15:0] v;
      process::self().srandom(32'd1234);

      // reset state
      @(negedge clk);
      chk(status, 4'h0, "R9 reset status");
      chk(reset_req, 0, "R8 reset req");

      // R2/R3: guard1 timeout
      do_reset(1'b1, 1'b1);
      @(negedge clk);
      chk(status, exp_status(1, 0), "R2 guard1 armed");
      measure_fire(1000, c);
      chk(c + 1, edges_to_fire(G1), "R3 guard1 expiry edge");
      exp_cause = 2'b01;
      @(negedge clk);
      chk(reset_req, 0, "R8 pulse width");
      chk(status, exp_status(0, 0), "R9 cause guard1");

      // R9: cause survives rst_n
      do_reset(1'b1, 1'b0);
      @(negedge clk);
      chk(status, exp_status(1, 0), "R9 cause kept over rst_n");

      // R7: wrong and junk writes in guard1
      wr(16'hBBC2);
      chk(status, exp_status(1, 0), "R7 guard2 cmd in guard1");
      wr(16'hEEA0);
      chk(status, exp_status(1, 0), "R7 junk in guard1");
      // R4: retire guard1
      wr(16'hEEA1);
      chk(status, exp_status(0, 1), "R4 guard2 armed");
      wr(16'hEEA1);
      chk(status, exp_status(0, 1), "R7 guard1 cmd in guard2");
      // R6: retire guard2
      wr(16'hBBC2);
      chk(status, exp_status(0, 0), "R6 guard2 retired");
      watch_quiet(edges_to_fire(G2) + 20, s);
      chk(s, 0, "R6 no request after retire");
      wr(16'hEEA1);
      chk(status, exp_status(0, 0), "R7 write while idle");

      // R5: guard2 timeout measured from capturing edge
      do_reset(1'b1, 1'b0);
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = 16'hEEA1;
      measure_fire(2000, c);
      cmd_we = 1'b0;
      chk(c, edges_to_fire(G2), "R5 guard2 expiry edge");
      exp_cause = 2'b10;
      @(negedge clk);
      chk(status, exp_status(0, 0), "R9 cause guard2");

      // R11 boundary: service on last allowed edge
      do_reset(1'b1, 1'b0);
      repeat (G1 * DIV - 1) @(negedge clk);
      wr(16'hEEA1);
      chk(status, exp_status(0, 1), "R11 service on last edge");
      // R11 boundary: service on expiry edge
      do_reset(1'b1, 1'b0);
      repeat (G1 * DIV) @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = 16'hEEA1;
      @(negedge clk);
      cmd_we = 1'b0;
      chk(reset_req, 1, "R11 timeout wins on tie");
      exp_cause = 2'b01;
      @(negedge clk);
      chk(status, exp_status(0, 0), "R11 tripped state");

      // R1/R10: strap low, then toggled
      do_reset(1'b0, 1'b0);
      @(negedge clk);
      strap_en = 1'b1;
      chk(status, exp_status(0, 0), "R1 disabled by strap");
      wr(16'hEEA1);
      watch_quiet(edges_to_fire(G1) + 20, s);
      chk(s, 0, "R10 late strap ignored");
      chk(status, exp_status(0, 0), "R10 still idle");

      // R9: por clears cause
      do_reset(1'b0, 1'b1);
      @(negedge clk);
      chk(status, 4'h0, "R9 por clears cause");

      // random mix
      for (int it = 0; it < 10; it++) begin
         do_reset(1'b1, 1'b0);
         if ($urandom_range(0, 2) == 0) begin
            measure_fire(1000, c);
            chk(c, edges_to_fire(G1), "R3 random guard1 expiry");
            exp_cause = 2'b01;
         end else begin
            for (int k = 0; k < 3; k++) begin
               v = 16'($urandom);
               if (v == 16'hEEA1) v = 16'h0000;
               wr(v);
            end
            chk(status, exp_status(1, 0), "R7 random junk");
            repeat ($urandom_range(0, 20)) @(negedge clk);
            wr(16'hEEA1);
            chk(status, exp_status(0, 1), "R4 random service");
            if ($urandom_range(0, 1) == 0) begin
               wr(16'hBBC2);
               chk(status, exp_status(0, 0), "R6 random retire");
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule